// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Word Memory

This block is a small word memory in which every word carries one extra state bit that marks it full or empty. A requester issues one access per cycle with an 8-bit operation modifier. The modifier selects a load, a store, an atomic swap or an element reset. It also selects whether the access updates the state bit, and whether it aborts when the state bit has the wrong value. Producer/consumer and lock-style synchronization can then be done per word in a single access.

Each accepted request returns a registered response one cycle later. The response carries the read data, a condition code that holds the full/empty state as it was before the access, and two mutually exclusive fault lines. The first is a synchronous trap for a full/empty mismatch; that access has no effect. The second is a privilege fault for a supervisor-only modifier issued in user mode; that access is not performed. Software handles the waiting that follows a trap. A reset of the block empties every word, as on allocation.

Top module: `fe_sync_mem`

## Requirements
- R1: The modifier is decoded as follows. Bits [3:2] give the class: 00 is element reset, 01 load, 10 store and 11 swap. Bit 1 set disables the full/empty trap. Bit 0 set enables the state-bit update. Bits [6:4] are ignored. 0x84 is therefore load-and-trap-if-empty.
- R2: Loads return the word in rdata_o. Variants: 0x86 is a plain read; 0x87 reads and sets empty; 0x84 traps if the word is empty; 0x85 traps if empty and otherwise reads and sets empty.
- R3: Stores write wdata_i. Variants: 0x8A is a plain write; 0x8B writes and sets full; 0x88 traps if the word is full; 0x89 traps if full and otherwise writes and sets full.
- R4: A swap writes wdata_i and returns the prior word. With bit 1 clear it traps if the word is full. With bit 0 set it sets the word full.
- R5: Every response that is not a privilege fault shows, on cc_full_o, the state bit of the addressed word as it was before the access.
- R6: A trapped access raises sync_trap_o, returns rdata_o = 0 and leaves both the data and the state bit unchanged.
- R7: With user_mode_i high, a modifier below 0x80 raises priv_fault_o. It performs no access, and it returns rdata_o = 0, cc_full_o = 0 and sync_trap_o = 0. In supervisor mode the same modifier acts as its low bits decode.
- R8: Element reset (class 00) clears the state bit to empty. It leaves the data unchanged, never traps and returns rdata_o = 0.
- R9: While rst_ni is low, all outputs are 0. After reset every word is empty and holds zero.
- R10: A request produces its response on the clock edge that samples it. In a cycle with no request, rsp_valid_o and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| user_mode_i | input | 1 | Request issued in user mode |
| mod_i | input | 8 | Operation modifier |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Store or swap data |
| rsp_valid_o | output | 1 | Response valid |
| rdata_o | output | DATA_W | Load or swap data |
| cc_full_o | output | 1 | Prior full/empty state (1 = full) |
| sync_trap_o | output | 1 | Full/empty trap, access aborted |
| priv_fault_o | output | 1 | Privilege fault, access not performed |

## Verification
The bench builds the block with DEPTH=8 and DATA_W=16. At these values every word can be walked through empty, full, trapped and reset states in directed sweeps. A few thousand random operations then also reach repeated state transitions on each address. The narrow data width keeps the address-derived write patterns distinct per word. Covering all sixteen class/variant combinations in both privilege modes is therefore cheap.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAR = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10,
    CLS_SWAP  = 2'b11
  } fe_cls_e;

  typedef struct packed {
    logic priv;        // privilege violation
    logic rd;          // returns word
    logic wr;          // writes word
    logic trap_empty;  // abort when empty
    logic trap_full;   // abort when full
    logic st_upd;      // update state bit
    logic st_val;      // new state value
  } fe_dec_t;
endpackage

// File: rtl/fe_decode.sv
module fe_decode
  import fe_pkg::*;
(
  input  logic       user_mode_i,
  input  logic [7:0] mod_i,
  output fe_dec_t    dec_o
);
  fe_cls_e cls;
  logic    no_trap, upd;

  assign cls     = fe_cls_e'(mod_i[3:2]);
  assign no_trap = mod_i[1];
  assign upd     = mod_i[0];

  always_comb begin
    dec_o      = '0;
    dec_o.priv = user_mode_i & ~mod_i[7];
    unique case (cls)
      CLS_LOAD: begin
        dec_o.rd         = 1'b1;
        dec_o.trap_empty = ~no_trap;
        dec_o.st_upd     = upd;
        dec_o.st_val     = 1'b0;
      end
      CLS_STORE: begin
        dec_o.wr        = 1'b1;
        dec_o.trap_full = ~no_trap;
        dec_o.st_upd    = upd;
        dec_o.st_val    = 1'b1;
      end
      CLS_SWAP: begin
        dec_o.rd        = 1'b1;
        dec_o.wr        = 1'b1;
        dec_o.trap_full = ~no_trap;
        dec_o.st_upd    = upd;
        dec_o.st_val    = 1'b1;
      end
      default: begin
        dec_o.st_upd = 1'b1;
        dec_o.st_val = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fe_word_array.sv
module fe_word_array #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              state_we_i,
  input  logic              state_i,
  output logic [DATA_W-1:0] data_o,
  output logic              state_o
);
  logic [DATA_W-1:0] words [DEPTH];
  logic [DEPTH-1:0]  full_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = (addr_i == ADDR_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words[g]  <= '0;
        full_q[g] <= 1'b0;
      end else begin
        if (hit && data_we_i)  words[g]  <= data_i;
        if (hit && state_we_i) full_q[g] <= state_i;
      end
    end
  end

  assign data_o  = words[addr_i];
  assign state_o = full_q[addr_i];
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              user_mode_i,
  input  logic [7:0]        mod_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cc_full_o,
  output logic              sync_trap_o,
  output logic              priv_fault_o
);
  fe_dec_t           dec;
  logic [DATA_W-1:0] cur_data;
  logic              cur_full;
  logic              trap, access, data_we, state_we;

  fe_decode u_dec (
    .user_mode_i(user_mode_i),
    .mod_i      (mod_i),
    .dec_o      (dec)
  );

  fe_word_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .data_we_i (data_we),
    .data_i    (wdata_i),
    .state_we_i(state_we),
    .state_i   (dec.st_val),
    .data_o    (cur_data),
    .state_o   (cur_full)
  );

  assign trap     = ~dec.priv & ((dec.trap_empty & ~cur_full) | (dec.trap_full & cur_full));
  assign access   = req_i & ~dec.priv & ~trap;
  assign data_we  = access & dec.wr;
  assign state_we = access & dec.st_upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rdata_o      <= '0;
      cc_full_o    <= 1'b0;
      sync_trap_o  <= 1'b0;
      priv_fault_o <= 1'b0;
    end else begin
      rsp_valid_o  <= req_i;
      rdata_o      <= (access && dec.rd) ? cur_data : '0;
      cc_full_o    <= req_i & ~dec.priv & cur_full;
      sync_trap_o  <= req_i & trap;
      priv_fault_o <= req_i & dec.priv;
    end
  end
endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       user_mode_i,
  input logic [7:0] mod_i,
  input logic       rsp_valid_o,
  input logic       sync_trap_o,
  input logic       priv_fault_o,
  input logic       data_we,
  input logic       state_we
);
  assert_rsp_follows_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o && !sync_trap_o && !priv_fault_o);
  assert_faults_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sync_trap_o, priv_fault_o}));
  assert_priv_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && user_mode_i && !mod_i[7] |=> priv_fault_o);
  assert_priv_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && user_mode_i && !mod_i[7] |-> !data_we && !state_we);
  assert_trap_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_trap_o |-> $past(!data_we && !state_we));
  assert_plain_load_no_trap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mod_i[7] && mod_i[3:2] == 2'b01 && mod_i[1] |=> !sync_trap_o);
  assert_clear_no_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mod_i[3:2] == 2'b00 |=> !sync_trap_o);
endmodule

bind fe_sync_mem fe_sync_mem_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .user_mode_i (user_mode_i),
  .mod_i       (mod_i),
  .rsp_valid_o (rsp_valid_o),
  .sync_trap_o (sync_trap_o),
  .priv_fault_o(priv_fault_o),
  .data_we     (data_we),
  .state_we    (state_we)
);

// File: tb/fe_sync_mem_tb.sv
module fe_sync_mem_tb;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic              user_mode_i = 1'b0;
  logic [7:0]        mod_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              rsp_valid_o, cc_full_o, sync_trap_o, priv_fault_o;
  logic [DATA_W-1:0] rdata_o;

  always #2.5 clk_i = ~clk_i;

  fe_sync_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (.*);

  int total = 0;
  int bad   = 0;

  logic [DATA_W-1:0] m_data [DEPTH];
  bit                m_full [DEPTH];

  bit                e_valid, e_cc, e_trap, e_priv;
  logic [DATA_W-1:0] e_rdata;
  string             e_tag = "R9";

  task automatic chk1(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk1(e_tag, "rsp_valid", DATA_W'(rsp_valid_o), DATA_W'(e_valid));
    chk1(e_tag, "rdata", rdata_o, e_rdata);
    chk1(e_priv ? e_tag : "R5", "cc_full", DATA_W'(cc_full_o), DATA_W'(e_cc));
    chk1(e_tag, "sync_trap", DATA_W'(sync_trap_o), DATA_W'(e_trap));
    chk1(e_tag, "priv_fault", DATA_W'(priv_fault_o), DATA_W'(e_priv));
  endtask

  // Behavioural model of one access
  task automatic model(bit req, bit user, logic [7:0] m, int a, logic [DATA_W-1:0] wd, string tag);
    bit p, tr, full, rd, wr, tre, trf, upd, sval;
    e_valid = req; e_rdata = '0; e_cc = 0; e_trap = 0; e_priv = 0;
    if (!req) begin e_tag = (tag == "") ? "R10" : tag; return; end
    p    = user && !m[7];
    full = m_full[a];
    rd = 0; wr = 0; tre = 0; trf = 0; upd = m[0]; sval = 0;
    case (m[3:2])
      2'b01: begin rd = 1; tre = !m[1]; sval = 0; end
      2'b10: begin wr = 1; trf = !m[1]; sval = 1; end
      2'b11: begin rd = 1; wr = 1; trf = !m[1]; sval = 1; end
      default: begin upd = 1; sval = 0; end
    endcase
    tr = !p && ((tre && !full) || (trf && full));
    e_priv = p;
    e_trap = tr;
    e_cc   = !p && full;
    if (!p && !tr) begin
      if (rd) e_rdata = m_data[a];
      if (wr) m_data[a] = wd;
      if (upd) m_full[a] = sval;
    end
    if (tag != "") e_tag = tag;
    else if (p) e_tag = "R7";
    else if (tr) e_tag = "R6";
    else case (m[3:2])
      2'b01: e_tag = "R2";
      2'b10: e_tag = "R3";
      2'b11: e_tag = "R4";
      default: e_tag = "R8";
    endcase
  endtask

  task automatic op(bit user, logic [7:0] m, int a, logic [DATA_W-1:0] wd, string tag = "");
    @(negedge clk_i);
    compare();
    req_i = 1'b1; user_mode_i = user; mod_i = m; addr_i = ADDR_W'(a); wdata_i = wd;
    model(1'b1, user, m, a, wd, tag);
  endtask

  task automatic idle(string tag = "");
    @(negedge clk_i);
    compare();
    req_i = 1'b0; user_mode_i = $urandom_range(0, 1); mod_i = 8'($urandom); addr_i = '0;
    model(1'b0, 1'b0, 8'h00, 0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_full[i] = 0; end
    e_valid = 0; e_rdata = '0; e_cc = 0; e_trap = 0; e_priv = 0;
    // R9: outputs quiet in reset
    repeat (3) begin @(negedge clk_i); compare(); end
    req_i = 1'b1; mod_i = 8'h8B;
    @(negedge clk_i); compare();
    req_i = 1'b0;
    rst_ni = 1'b1;
    idle("R10");

    // R9 / R1: after reset every word empty, 0x84 traps everywhere
    for (int a = 0; a < DEPTH; a++) op(1'b1, 8'h84, a, '0, "R9");
    // R8 behaviour when nothing is full yet
    op(1'b1, 8'h80, 0, '0);
    // R3: plain store, no state change
    for (int a = 0; a < DEPTH; a++) op(1'b1, 8'h8A, a, DATA_W'(16'h1100 + a));
    // R2: plain read of empty word returns data, cc=0
    for (int a = 0; a < DEPTH; a++) op(1'b1, 8'h86, a, '0);
    // R3: write-set-full on empty words
    for (int a = 0; a < DEPTH; a++) op(1'b1, 8'h89, a, DATA_W'(16'h2200 + a));
    // R6: trap-if-full store on full words, then read to confirm unchanged
    for (int a = 0; a < DEPTH; a++) op(1'b1, 8'h88, a, 16'hDEAD);
    for (int a = 0; a < DEPTH; a++) op(1'b1, 8'h84, a, '0);
    // R1: bits [6:4] ignored
    op(1'b1, 8'hF4, 1, '0, "R1");
    op(1'b1, 8'hB5, 2, '0, "R1");
    op(1'b1, 8'h84, 2, '0, "R1");
    // R4: swap traps on full, plain swap, then swap-set-full on empty
    op(1'b1, 8'h8C, 3, 16'h3333);
    op(1'b1, 8'h8E, 3, 16'h4444);
    op(1'b1, 8'h80, 3, '0);
    op(1'b1, 8'h8D, 3, 16'h5555);
    op(1'b1, 8'h86, 3, '0);
    // R7: privileged modifier in user mode, then in supervisor mode
    op(1'b1, 8'h0A, 4, 16'hBEEF);
    op(1'b1, 8'h00, 4, '0);
    op(1'b1, 8'h86, 4, '0);
    op(1'b0, 8'h0A, 4, 16'hBEEF);
    op(1'b0, 8'h06, 4, '0);
    // R8: clear element keeps data
    op(1'b1, 8'h83, 5, '0);
    op(1'b1, 8'h86, 5, '0);
    op(1'b1, 8'h84, 5, '0);
    idle();

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else op(1'($urandom_range(0, 3) != 0),
              ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 127)) : 8'h80 | 8'($urandom_range(0, 15)),
              $urandom_range(0, DEPTH - 1), DATA_W'($urandom));
    end
    idle();
    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule